// File: doc/BRIEF.md
# Strobe-Clocked Serial Register Slave

This block is the device end of a three-wire synchronous serial link that a host drives by toggling general-purpose pins in software. The host frames each transfer by pulsing a clear line low and then high, then clocks bits with a strobe line and sends them on a data-in line. The block answers on a data-out line. A fast on-chip clock oversamples all three pins. The block synchronises them, finds the edges of clear and strobe, and decodes each transfer into a read or a write of one 16-bit register.

A transfer opens with an 8-bit command: one read flag followed by a 7-bit address. A write then takes 16 data bits from data-in. A read returns 16 bits on data-out, presented so that the host can sample each bit after a falling edge of strobe. The register bank has two fixed identification words and eight writable control words. The control words drive three parallel output buses: function enables, pin-driver enables and pin directions.

Top module: `strobe_reg_slave`

## Requirements
- R1: After reset every writable register reads 0, all three control buses are 0 and `dout_o` is 0.
- R2: A clear line held low drops any partial transfer and leaves every register unchanged. The next rising edge of clear starts a new command.
- R3: The first 8 strobe rising edges after clear capture the command most significant bit first. Command bit 7 set to 1 selects a read, set to 0 selects a write, and bits 6..0 are the address.
- R4: After a write command, the next 16 strobe rising edges capture data most significant bit first. The target register changes only when the 16th bit is captured.
- R5: After a read command, the k-th strobe rising edge (k = 1..16) makes `dout_o` show bit 16-k of the addressed register. `dout_o` holds that bit until the next rising edge, so the host reads it after the falling edge that follows.
- R6: Address 0 is read-only. It returns `{PLAT_HI, 8'h01}`, which is 16'h5301 by default, so its low byte is always the manufacturer code 0x01.
- R7: Address 1 is read-only. It returns build in bits 15:12, major in bits 11:8, minor in bits 7:4 and patch in bits 3:0. Major is always 0, and the default value is 16'h2037.
- R8: Addresses 8–9, 16–18 and 24–26 are read/write. `func_en_o` is {reg9, reg8}, `gpio_en_o` is {reg18, reg17, reg16} and `gpio_dir_o` is {reg26, reg25, reg24}, with the lower address in the lower 16 bits.
- R9: A read of any other address returns 0. A write to addresses 0 or 1 or to an unmapped address changes nothing.
- R10: While `en_i` is low, `dout_o` is 0 and any transfer is dropped. Strobes that arrive after `en_i` returns high are ignored until the next clear rising edge.
- R11: After the 16th data bit of a transfer, further strobe edges have no effect until the next clear rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the strobe toggle rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Global enable; low forces idle and data-out low |
| clr_i | input | 1 | Clear line from host (asynchronous pin) |
| stb_i | input | 1 | Strobe line from host (asynchronous pin) |
| din_i | input | 1 | Serial data from host (asynchronous pin) |
| dout_o | output | 1 | Serial read data to host |
| func_en_o | output | 32 | Function-enable registers, address 8 in bits 15:0 |
| gpio_en_o | output | 48 | Pin-driver enable registers, address 16 in bits 15:0 |
| gpio_dir_o | output | 48 | Pin-direction registers, address 24 in bits 15:0 |

## Verification
Every writable register gets its own data word. The words are chosen with alternating, sparse and all-ones patterns, so a bit-order, address-decode or bank-slicing fault lands on a wrong output bit. Reads of the fixed words and a read of 16'h8001 separate a correct most-significant-first order from a reversed or off-by-one shift. Transfers are cut short by clear, by a low enable and by an incomplete write of 15 bits, which shows whether a commit happens early. Extra strobes are sent after a finished transfer and after enable returns without a clear, which separates correct framing from a block that keeps shifting.

// File: rtl/srs_pkg.sv
package srs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_WR,
        ST_RD,
        ST_DONE
    } xfer_state_e;

    localparam int ADDR_PLAT = 0;
    localparam int ADDR_FW   = 1;

    localparam int FUNC_N = 2;
    localparam int GEN_N  = 3;
    localparam int DIR_N  = 3;

    localparam int NUM_BANKS = 3;
    localparam int BANK_BASE [NUM_BANKS] = '{8, 16, 24};
    localparam int BANK_LEN  [NUM_BANKS] = '{FUNC_N, GEN_N, DIR_N};

    function automatic int slot_base(int bank);
        int acc;
        acc = 0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (b < bank) acc += BANK_LEN[b];
        end
        return acc;
    endfunction

    localparam int NUM_SLOTS = slot_base(NUM_BANKS);

    function automatic int addr_to_slot(int addr);
        int res;
        res = NUM_SLOTS;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr >= BANK_BASE[b] && addr < BANK_BASE[b] + BANK_LEN[b])
                res = slot_base(b) + addr - BANK_BASE[b];
        end
        return res;
    endfunction

endpackage

// File: rtl/srs_pin_sync.sv
module srs_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] level_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d[0] = pin_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], pin_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign level_o = chain_q[STAGES-1];

endmodule

// File: rtl/srs_edge_det.sv
module srs_edge_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb prev_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/srs_xfer_fsm.sv
module srs_xfer_fsm
    import srs_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              clr_lvl_i,
    input  logic              clr_rise_i,
    input  logic              stb_rise_i,
    input  logic              din_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              dout_o
);
    localparam int CMD_W     = ADDR_W + 1;
    localparam int CNT_MAX   = (DATA_W > CMD_W) ? DATA_W : CMD_W;
    localparam int CNT_W     = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        xfer_state_e       st;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  cnt;
        logic              dout;
    } fsm_t;

    fsm_t q, n;
    logic [CMD_W-1:0] cmd_nx;
    logic [CNT_W-1:0] rd_idx;

    always_comb begin
        n         = q;
        wr_en_o   = 1'b0;
        cmd_nx    = {q.cmd[CMD_W-2:0], din_i};
        wr_data_o = {q.data[DATA_W-2:0], din_i};
        rd_idx    = DATA_LAST - q.cnt;
        if (!en_i || !clr_lvl_i) begin
            n.st   = ST_IDLE;
            n.cnt  = '0;
            n.dout = 1'b0;
        end else if (clr_rise_i) begin
            n.st   = ST_CMD;
            n.cnt  = '0;
            n.cmd  = '0;
            n.data = '0;
            n.dout = 1'b0;
        end else if (stb_rise_i) begin
            case (q.st)
                ST_CMD: begin
                    n.cmd = cmd_nx;
                    if (q.cnt == CMD_LAST) begin
                        n.cnt = '0;
                        n.st  = cmd_nx[CMD_W-1] ? ST_RD : ST_WR;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                ST_WR: begin
                    n.data = wr_data_o;
                    if (q.cnt == DATA_LAST) begin
                        wr_en_o = 1'b1;
                        n.st    = ST_DONE;
                    end else begin
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                ST_RD: begin
                    n.dout = rd_data_i[rd_idx];
                    if (q.cnt == DATA_LAST) n.st = ST_DONE;
                    else                    n.cnt = q.cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.cmd  <= '0;
            q.data <= '0;
            q.cnt  <= '0;
            q.dout <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign addr_o = q.cmd[ADDR_W-1:0];
    assign dout_o = q.dout;

    // R5: read data only moves on a strobe rising edge
    p_dout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && clr_lvl_i && !clr_rise_i && !stb_rise_i && q.st == ST_RD)
        |=> $stable(dout_o));

    // R10: disable forces idle and quiet output
    p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (q.st == ST_IDLE && !dout_o));

    // R11: a finished transfer stays finished until clear
    p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && clr_lvl_i && !clr_rise_i && q.st == ST_DONE)
        |=> (q.st == ST_DONE && !wr_en_o));

endmodule

// File: rtl/srs_reg_file.sv
module srs_reg_file
    import srs_pkg::*;
#(
    parameter int          ADDR_W   = 7,
    parameter int          DATA_W   = 16,
    parameter logic [7:0]  PLAT_HI  = 8'h53,
    parameter logic [3:0]  FW_BUILD = 4'h2,
    parameter logic [3:0]  FW_MINOR = 4'h3,
    parameter logic [3:0]  FW_PATCH = 4'h7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        wr_en_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    output logic [DATA_W-1:0]           rd_data_o,
    output logic [NUM_SLOTS*DATA_W-1:0] bank_o
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam logic [DATA_W-1:0] PLAT_VAL = DATA_W'({PLAT_HI, 8'h01});
    localparam logic [DATA_W-1:0] FW_VAL   = DATA_W'({FW_BUILD, 4'h0, FW_MINOR, FW_PATCH});

    logic [NUM_SLOTS-1:0][DATA_W-1:0] bank_d, bank_q;
    int                slot;
    logic              hit;
    logic [SLOT_W-1:0] sidx;

    always_comb begin
        slot   = addr_to_slot(int'(addr_i));
        hit    = (slot < NUM_SLOTS);
        sidx   = SLOT_W'(slot);
        bank_d = bank_q;
        if (wr_en_i && hit) bank_d[sidx] = wr_data_i;
        if (addr_i == ADDR_W'(ADDR_PLAT))      rd_data_o = PLAT_VAL;
        else if (addr_i == ADDR_W'(ADDR_FW))   rd_data_o = FW_VAL;
        else if (hit)                          rd_data_o = bank_q[sidx];
        else                                   rd_data_o = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bank_o = bank_q;

    // R4: contents change only on a commit
    p_hold_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(bank_q));

    // R9: writes to identification words leave the bank untouched
    p_ro_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (addr_i == ADDR_W'(ADDR_PLAT) || addr_i == ADDR_W'(ADDR_FW)))
        |=> $stable(bank_q));

endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave
    import srs_pkg::*;
#(
    parameter int         ADDR_W      = 7,
    parameter int         DATA_W      = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] PLAT_HI     = 8'h53,
    parameter logic [3:0] FW_BUILD    = 4'h2,
    parameter logic [3:0] FW_MINOR    = 4'h3,
    parameter logic [3:0] FW_PATCH    = 4'h7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_i,
    input  logic                       clr_i,
    input  logic                       stb_i,
    input  logic                       din_i,
    output logic                       dout_o,
    output logic [FUNC_N*DATA_W-1:0]   func_en_o,
    output logic [GEN_N*DATA_W-1:0]    gpio_en_o,
    output logic [DIR_N*DATA_W-1:0]    gpio_dir_o
);
    localparam int FUNC_LO = slot_base(0) * DATA_W;
    localparam int GEN_LO  = slot_base(1) * DATA_W;
    localparam int DIR_LO  = slot_base(2) * DATA_W;

    logic [2:0]              pins_s;
    logic [1:0]              rise;
    logic [ADDR_W-1:0]       addr;
    logic                    wr_en;
    logic [DATA_W-1:0]       wr_data;
    logic [DATA_W-1:0]       rd_data;
    logic [NUM_SLOTS*DATA_W-1:0] bank;

    srs_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({clr_i, stb_i, din_i}),
        .level_o(pins_s)
    );

    srs_edge_det #(.WIDTH(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(pins_s[2:1]),
        .rise_o (rise)
    );

    srs_xfer_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .clr_lvl_i (pins_s[2]),
        .clr_rise_i(rise[1]),
        .stb_rise_i(rise[0]),
        .din_i     (pins_s[0]),
        .rd_data_i (rd_data),
        .addr_o    (addr),
        .wr_en_o   (wr_en),
        .wr_data_o (wr_data),
        .dout_o    (dout_o)
    );

    srs_reg_file #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PLAT_HI (PLAT_HI),
        .FW_BUILD(FW_BUILD),
        .FW_MINOR(FW_MINOR),
        .FW_PATCH(FW_PATCH)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr),
        .wr_en_i  (wr_en),
        .wr_data_i(wr_data),
        .rd_data_o(rd_data),
        .bank_o   (bank)
    );

    assign func_en_o  = bank[FUNC_LO +: FUNC_N*DATA_W];
    assign gpio_en_o  = bank[GEN_LO  +: GEN_N*DATA_W];
    assign gpio_dir_o = bank[DIR_LO  +: DIR_N*DATA_W];

endmodule

// File: tb/test_strobe_reg_slave.sv
`timescale 1ns/1ps
module test_strobe_reg_slave;

    localparam int HPH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1, clr = 1'b0, stb = 1'b1, din = 1'b0;
    logic dout;
    logic [31:0] func_en;
    logic [47:0] gpio_en, gpio_dir;

    int total = 0, bad = 0, cyc = 0;
    logic [15:0] rv;

    always #2 clk = ~clk;

    strobe_reg_slave i_strobe_reg_slave (
        .clk(clk), .rst_n(rst_n), .en_i(en), .clr_i(clr), .stb_i(stb),
        .din_i(din), .dout_o(dout), .func_en_o(func_en),
        .gpio_en_o(gpio_en), .gpio_dir_o(gpio_dir)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] mreg [0:127];
    logic [2:0]  pq [$];
    logic [2:0]  cur;
    logic        s_clr, s_stb, m_dout;
    int          m_st, m_cnt;
    logic [7:0]  m_cmd;
    logic [15:0] m_data;

    function automatic bit is_wr(int a);
        return (a == 8 || a == 9 || (a >= 16 && a <= 18) || (a >= 24 && a <= 26));
    endfunction

    function automatic logic [15:0] m_read(int a);
        if (a == 0) return 16'h5301;
        if (a == 1) return 16'h2037;
        if (is_wr(a)) return mreg[a];
        return 16'h0;
    endfunction

    initial for (int i = 0; i < 128; i++) mreg[i] = 16'h0;

    always @(posedge clk) begin
        if (!rst_n) begin
            pq.delete();
            pq.push_back(3'b000);
            pq.push_back(3'b000);
            s_clr = 0; s_stb = 0; m_dout = 0; m_st = 0; m_cnt = 0;
            m_cmd = 0; m_data = 0;
        end else begin
            pq.push_back({clr, stb, din});
            cur = pq.pop_front();
            if (!en || !cur[2]) begin
                m_st = 0; m_cnt = 0; m_dout = 0;
            end else if (!s_clr) begin
                m_st = 1; m_cnt = 0; m_cmd = 0; m_data = 0; m_dout = 0;
            end else if (cur[1] && !s_stb) begin
                case (m_st)
                    1: begin
                        m_cmd = {m_cmd[6:0], cur[0]};
                        m_cnt++;
                        if (m_cnt == 8) begin m_cnt = 0; m_st = m_cmd[7] ? 3 : 2; end
                    end
                    2: begin
                        m_data = {m_data[14:0], cur[0]};
                        m_cnt++;
                        if (m_cnt == 16) begin
                            if (is_wr(int'(m_cmd[6:0]))) mreg[m_cmd[6:0]] = m_data;
                            m_st = 4;
                        end
                    end
                    3: begin
                        m_dout = m_read(int'(m_cmd[6:0]))[15 - m_cnt];
                        m_cnt++;
                        if (m_cnt == 16) m_st = 4;
                    end
                    default: ;
                endcase
            end
            s_clr = cur[2];
            s_stb = cur[1];
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 dout vs model", {63'd0, dout}, {63'd0, m_dout});
            chk("R8 func_en vs model", {32'd0, func_en}, {32'd0, mreg[9], mreg[8]});
            chk("R8 gpio_en vs model", {16'd0, gpio_en}, {16'd0, mreg[18], mreg[17], mreg[16]});
            chk("R8 gpio_dir vs model", {16'd0, gpio_dir}, {16'd0, mreg[26], mreg[25], mreg[24]});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- host-side stimulus ----------------
    task automatic wt();
        repeat (HPH) @(negedge clk);
    endtask

    task automatic do_clear();
        clr = 1'b0; wt(); clr = 1'b1; wt();
    endtask

    task automatic send_cmd(input bit rd, input logic [6:0] a);
        logic [7:0] c;
        c = {rd, a};
        for (int i = 7; i >= 0; i--) begin
            stb = 1'b0; din = c[i]; wt(); stb = 1'b1; wt();
        end
    endtask

    task automatic send_data(input logic [15:0] v, input int n);
        stb = 1'b0; wt();
        for (int i = 0; i < n; i++) begin
            din = v[15 - i]; stb = 1'b1; wt(); stb = 1'b0; wt();
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] v);
        do_clear(); send_cmd(1'b0, a); send_data(v, 16); stb = 1'b1; wt();
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] v);
        do_clear(); send_cmd(1'b1, a);
        stb = 1'b0; wt();
        for (int i = 0; i < 16; i++) begin
            stb = 1'b1; wt(); stb = 1'b0; wt();
            v[15 - i] = dout;
        end
        stb = 1'b1; wt();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        // R1: reset state
        chk("R1 dout after reset", {63'd0, dout}, 64'd0);
        chk("R1 func_en after reset", {32'd0, func_en}, 64'd0);
        chk("R1 gpio_en after reset", {16'd0, gpio_en}, 64'd0);
        chk("R1 gpio_dir after reset", {16'd0, gpio_dir}, 64'd0);
        clr = 1'b1; wt();

        // R6, R7: identification words
        rd(7'd0, rv); chk("R6 platform id", {48'd0, rv}, 64'h5301);
        chk("R6 manufacturer byte", {56'd0, rv[7:0]}, 64'h01);
        rd(7'd1, rv); chk("R7 firmware id", {48'd0, rv}, 64'h2037);
        chk("R7 major field zero", {60'd0, rv[11:8]}, 64'h0);

        // R3, R4, R8: writes then read back
        wr(7'd8, 16'hA5C3);  wr(7'd9, 16'h0F0F);
        wr(7'd16, 16'h1234); wr(7'd17, 16'h8001); wr(7'd18, 16'hFFFF);
        wr(7'd24, 16'h5555); wr(7'd25, 16'hAAAA); wr(7'd26, 16'h0001);
        chk("R8 func_en bus", {32'd0, func_en}, {32'd0, 32'h0F0FA5C3});
        chk("R8 gpio_en bus", {16'd0, gpio_en}, {16'd0, 48'hFFFF80011234});
        chk("R8 gpio_dir bus", {16'd0, gpio_dir}, {16'd0, 48'h0001AAAA5555});
        rd(7'd8, rv);  chk("R3 read back 8", {48'd0, rv}, 64'hA5C3);
        rd(7'd16, rv); chk("R8 read back 16", {48'd0, rv}, 64'h1234);
        rd(7'd25, rv); chk("R8 read back 25", {48'd0, rv}, 64'hAAAA);
        rd(7'd17, rv); chk("R5 msb-first 8001", {48'd0, rv}, 64'h8001);

        // R9: read-only and unmapped
        wr(7'd0, 16'hBEEF); wr(7'd1, 16'hBEEF); wr(7'd5, 16'hBEEF); wr(7'd100, 16'hBEEF);
        rd(7'd0, rv);   chk("R9 platform unchanged", {48'd0, rv}, 64'h5301);
        rd(7'd1, rv);   chk("R9 firmware unchanged", {48'd0, rv}, 64'h2037);
        rd(7'd5, rv);   chk("R9 unmapped 5 reads 0", {48'd0, rv}, 64'h0);
        rd(7'd100, rv); chk("R9 unmapped 100 reads 0", {48'd0, rv}, 64'h0);
        rd(7'd127, rv); chk("R9 unmapped 127 reads 0", {48'd0, rv}, 64'h0);
        chk("R9 buses unchanged", {32'd0, func_en}, {32'd0, 32'h0F0FA5C3});

        // R2: clear aborts a partial write
        do_clear(); send_cmd(1'b0, 7'd8); send_data(16'h1111, 10);
        do_clear();
        chk("R2 abort leaves reg 8", {48'd0, func_en[15:0]}, 64'hA5C3);
        wr(7'd8, 16'h7E81);
        rd(7'd8, rv); chk("R2 new transfer after clear", {48'd0, rv}, 64'h7E81);

        // R4: no commit before the 16th bit
        do_clear(); send_cmd(1'b0, 7'd9); send_data(16'h3C3C, 15);
        chk("R4 no commit after 15 bits", {48'd0, func_en[31:16]}, 64'h0F0F);
        din = 1'b0; stb = 1'b1; wt(); stb = 1'b0; wt();
        chk("R4 commit on 16th bit", {48'd0, func_en[31:16]}, 64'h3C3C);

        // R11: extra strobes after completion
        send_data(16'hFFFF, 16); stb = 1'b1; wt();
        chk("R11 extra strobes ignored", {48'd0, func_en[31:16]}, 64'h3C3C);

        // R10: enable low mid-read
        do_clear(); send_cmd(1'b1, 7'd18);
        stb = 1'b0; wt(); stb = 1'b1; wt(); stb = 1'b0; wt();
        chk("R10 first read bit before disable", {63'd0, dout}, 64'd1);
        en = 1'b0; wt();
        chk("R10 dout low when disabled", {63'd0, dout}, 64'd0);
        en = 1'b1; wt();
        send_cmd(1'b0, 7'd24); send_data(16'h0000, 16); stb = 1'b1; wt();
        chk("R10 strobes without clear ignored", {48'd0, gpio_dir[15:0]}, 64'h5555);
        rd(7'd24, rv); chk("R10 reg 24 intact", {48'd0, rv}, 64'h5555);

        repeat (10) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule